// File: doc/BRIEF.md
# Packet Register-Access Command Engine

This block turns a byte stream of compact read/write commands into accesses on an internal memory bus. A host transport, for example the payload of a UDP datagram, delivers the bytes one at a time. For each command the engine decodes a two-byte header. It then takes an optional two-byte address and, for writes, the data. It performs a number of 8-, 16- or 32-bit transfers against one of several address spaces. Read data goes back to the host as a byte stream.

Each space keeps its own address register. A command that carries no address continues from the address the previous command to that space left behind. This makes long block transfers cheap, because the host sends the address once. One space can only be accessed 16 bits at a time and has a write-protected region at its bottom. Two selector codes name no space at all.

Both byte streams use valid/ready. An input byte is consumed on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while the engine is waiting on the bus or waiting to hand read data to the output. An output byte is delivered on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold their values. The bus is a request/ready handshake: a transfer completes on the edge where both `bus_req` and `bus_ready` are high.

Top module: `cmd_engine`

## Requirements
- R1: Every multi-byte field is taken and produced least significant byte first: the header (low byte holds the count and increment flag), the address, write data and read response data.
- R2: Header bit 15 means write, bit 14 means an address follows, bits 12:10 select the space, bits 9:8 give the size (00 = 8-bit, 01 = 16-bit, 10 or 11 = 32-bit), bit 7 enables increment and bits 6:0 give the transfer count. A count of 0 performs exactly one transfer.
- R3: A read issues one bus read per transfer and returns the low width bytes of `bus_rdata`, LSB first.
- R4: A write collects width data bytes per transfer and issues one bus write with those bytes packed little-endian into `bus_wdata`.
- R5: Addresses are byte addresses. With increment set, the address advances by the transfer width after each transfer. Without it, all transfers of the command use the same address.
- R6: A command without an address uses the value its space's address register holds after the previous command to that space. Each space's register is independent of the others.
- R7: Space 2 always transfers 16-bit units, whatever the size code. A write there to a byte address below 0x20 issues no bus request, but its data is consumed and the address still advances.
- R8: Spaces 6 and 7 issue no bus request. Reads from them return zero bytes, and writes to them consume and discard their data.
- R9: Once raised, `bus_req` stays high with `bus_we`, `bus_space`, `bus_size`, `bus_addr` and `bus_wdata` unchanged until `bus_ready` is seen.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. A stalled output never corrupts or drops response bytes.
- R11: After reset, `in_ready` is high, `out_valid` and `bus_req` are low, and every space's address register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Command stream byte |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Engine accepts a command byte |
| out_data | output | 8 | Response stream byte |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Host accepts a response byte |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus transfer is a write |
| bus_space | output | 3 | Address space selector |
| bus_size | output | 2 | Transfer size code (0 = 8, 1 = 16, 2 = 32 bit) |
| bus_addr | output | 16 | Byte address |
| bus_wdata | output | 32 | Write data, little-endian |
| bus_rdata | input | 32 | Read data, little-endian |
| bus_ready | input | 1 | Target completes the transfer |

## Verification
Draining a response and parsing the next command can happen in the same cycle. After the engine hands the last read word of a command to its output serializer, it immediately accepts the header bytes of the next command. So `out_valid` and `in_ready` are both high while bytes flow in both directions. The bench provokes this by holding `out_ready` low two cycles in three and slowing the bus to a four-cycle response, while a second read command follows the first without a gap. It then checks that the concatenated response holds every byte of both commands in order, each taken from the right space and address.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

  typedef enum logic [2:0] {
    ST_H0,
    ST_H1,
    ST_A0,
    ST_A1,
    ST_WD,
    ST_BUS,
    ST_RSP,
    ST_ADV
  } eng_state_t;

  typedef struct packed {
    logic       we;
    logic       has_addr;
    logic [2:0] space;
    logic [1:0] size;
    logic       inc;
  } cmd_hdr_t;

  function automatic cmd_hdr_t decode_hi(input logic [7:0] hi, input logic inc_bit);
    cmd_hdr_t h;
    h.we       = hi[7];
    h.has_addr = hi[6];
    h.space    = hi[4:2];
    h.size     = hi[1:0];
    h.inc      = inc_bit;
    return h;
  endfunction

endpackage

// File: rtl/cmd_addr_bank.sv
module cmd_addr_bank #(
  parameter int AW      = 16,
  parameter int SPACE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SPACE_W-1:0] sel,
  input  logic               load_en,
  input  logic [AW-1:0]      load_val,
  input  logic               adv_en,
  input  logic [2:0]         adv_by,
  output logic [AW-1:0]      cur
);
  localparam int NSEL = 1 << SPACE_W;

  logic [NSEL*AW-1:0] flat;

  for (genvar i = 0; i < NSEL; i++) begin : g_reg
    logic [AW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (sel == SPACE_W'(i)) begin
        if (load_en) begin
          q <= load_val;
        end else if (adv_en) begin
          q <= q + AW'(adv_by);
        end
      end
    end
    assign flat[i*AW +: AW] = q;
  end

  assign cur = flat[sel*AW +: AW];

  // An increment only ever moves by a legal transfer width
  AST_ADV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |-> (adv_by == 3'd1 || adv_by == 3'd2 || adv_by == 3'd4)); // R5

  // With no load and no advance, the selected register keeps its value
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !adv_en) ##1 $stable(sel) |-> $stable(cur)); // R6

endmodule

// File: rtl/cmd_xfer_policy.sv
module cmd_xfer_policy #(
  parameter int AW         = 16,
  parameter int NUM_SPACES = 6,
  parameter int RO_SPACE   = 2,
  parameter int RO_LIMIT   = 32
) (
  input  logic [2:0]    space,
  input  logic [1:0]    size_code,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic [2:0]    width,
  output logic [1:0]    bus_size,
  output logic          skip
);
  localparam logic [AW-1:0] RO_LIM = AW'(RO_LIMIT);

  logic restricted;
  logic valid_space;

  assign restricted  = (space == 3'(RO_SPACE));
  assign valid_space = (32'(space) < NUM_SPACES);

  always_comb begin
    if (restricted) begin
      width    = 3'd2;
      bus_size = 2'd1;
    end else begin
      unique case (size_code)
        2'd0:    begin width = 3'd1; bus_size = 2'd0; end
        2'd1:    begin width = 3'd2; bus_size = 2'd1; end
        default: begin width = 3'd4; bus_size = 2'd2; end
      endcase
    end
    skip = !valid_space || (we && restricted && (addr < RO_LIM));
  end

endmodule

// File: rtl/cmd_resp_ser.sv
module cmd_resp_ser #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic [2:0]    load_nbytes,
  output logic          idle,
  output logic [7:0]    out_data,
  output logic          out_valid,
  input  logic          out_ready
);
  logic [DW-1:0] shreg;
  logic [2:0]    left;

  assign idle      = (left == 3'd0);
  assign out_valid = !idle;
  assign out_data  = shreg[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load && idle) begin
      shreg <= load_data;
      left  <= load_nbytes;
    end else if (out_valid && out_ready) begin
      shreg <= shreg >> 8;
      left  <= left - 3'd1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle); // R10

endmodule

// File: rtl/cmd_engine.sv
module cmd_engine #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int NUM_SPACES = 6,
  parameter int RO_SPACE   = 2,
  parameter int RO_LIMIT   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [7:0]    out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          bus_req,
  output logic          bus_we,
  output logic [2:0]    bus_space,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready
);
  import cmd_pkg::*;

  localparam int SPACE_W = 3;
  localparam logic [AW-1:0] RO_LIM = AW'(RO_LIMIT);

  eng_state_t    state;
  cmd_hdr_t      hdr;
  logic [7:0]    hdr_lo;
  logic [7:0]    addr_lo;
  logic [7:0]    remain;
  logic [1:0]    byte_idx;
  logic [DW-1:0] wbuf;
  logic [DW-1:0] rhold;

  logic          in_fire;
  logic [AW-1:0] cur_addr;
  logic          bank_load;
  logic          bank_adv;
  logic [2:0]    width;
  logic [1:0]    size_eff;
  logic          skip;
  logic          ser_idle;
  logic          ser_load;

  assign in_ready = (state == ST_H0) || (state == ST_H1) || (state == ST_A0) ||
                    (state == ST_A1) || (state == ST_WD);
  assign in_fire  = in_valid && in_ready;

  assign bank_load = (state == ST_A1) && in_fire;
  assign bank_adv  = (state == ST_ADV) && hdr.inc;
  assign ser_load  = (state == ST_RSP) && ser_idle;

  cmd_addr_bank #(.AW(AW), .SPACE_W(SPACE_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (hdr.space),
    .load_en  (bank_load),
    .load_val ({in_data, addr_lo}),
    .adv_en   (bank_adv),
    .adv_by   (width),
    .cur      (cur_addr)
  );

  cmd_xfer_policy #(
    .AW(AW), .NUM_SPACES(NUM_SPACES), .RO_SPACE(RO_SPACE), .RO_LIMIT(RO_LIMIT)
  ) u_policy (
    .space     (hdr.space),
    .size_code (hdr.size),
    .we        (hdr.we),
    .addr      (cur_addr),
    .width     (width),
    .bus_size  (size_eff),
    .skip      (skip)
  );

  cmd_resp_ser #(.DW(DW)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (ser_load),
    .load_data   (rhold),
    .load_nbytes (width),
    .idle        (ser_idle),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready)
  );

  assign bus_req   = (state == ST_BUS) && !skip;
  assign bus_we    = hdr.we;
  assign bus_space = hdr.space;
  assign bus_size  = size_eff;
  assign bus_addr  = cur_addr;
  assign bus_wdata = wbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_H0;
      hdr      <= '0;
      hdr_lo   <= '0;
      addr_lo  <= '0;
      remain   <= '0;
      byte_idx <= '0;
      wbuf     <= '0;
      rhold    <= '0;
    end else begin
      unique case (state)
        ST_H0: if (in_fire) begin
          hdr_lo <= in_data;
          state  <= ST_H1;
        end
        ST_H1: if (in_fire) begin
          hdr      <= decode_hi(in_data, hdr_lo[7]);
          remain   <= (hdr_lo[6:0] == 7'd0) ? 8'd1 : {1'b0, hdr_lo[6:0]};
          byte_idx <= '0;
          wbuf     <= '0;
          if (in_data[6])      state <= ST_A0;
          else if (in_data[7]) state <= ST_WD;
          else                 state <= ST_BUS;
        end
        ST_A0: if (in_fire) begin
          addr_lo <= in_data;
          state   <= ST_A1;
        end
        ST_A1: if (in_fire) begin
          state <= hdr.we ? ST_WD : ST_BUS;
        end
        ST_WD: if (in_fire) begin
          wbuf[byte_idx*8 +: 8] <= in_data;
          byte_idx <= byte_idx + 2'd1;
          if ({1'b0, byte_idx} == width - 3'd1) state <= ST_BUS;
        end
        ST_BUS: begin
          if (skip) begin
            rhold <= '0;
            state <= hdr.we ? ST_ADV : ST_RSP;
          end else if (bus_ready) begin
            rhold <= bus_rdata;
            state <= hdr.we ? ST_ADV : ST_RSP;
          end
        end
        ST_RSP: if (ser_idle) begin
          state <= ST_ADV;
        end
        ST_ADV: begin
          remain   <= remain - 8'd1;
          byte_idx <= '0;
          wbuf     <= '0;
          if (remain == 8'd1) state <= ST_H0;
          else                state <= hdr.we ? ST_WD : ST_BUS;
        end
        default: state <= ST_H0;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) &&
                                 $stable(bus_space) && $stable(bus_size) &&
                                 $stable(bus_wdata))); // R9

  AST_RO_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_space == 3'(RO_SPACE)) |-> (bus_addr >= RO_LIM)); // R7

  AST_RO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_space == 3'(RO_SPACE)) |-> (bus_size == 2'd1)); // R7

  AST_NO_BAD_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (32'(bus_space) < NUM_SPACES)); // R8

  AST_NO_INPUT_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !in_ready); // R10

endmodule

// File: tb/cmd_engine_tb.sv
module cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        bus_req;
  logic        bus_we;
  logic [2:0]  bus_space;
  logic [1:0]  bus_size;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int bus_delay = 0;
  int bp_mode = 0;
  int bus_cnt = 0;
  int rx_cnt = 0;
  int wait_n = 0;
  int bp_phase = 0;
  int cycles = 0;
  logic [7:0] rx_buf [0:255];
  logic [7:0] mem [0:5][0:255];

  always #4 clk = ~clk;

  cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  function automatic logic [7:0] init_byte(int s, int a);
    return 8'((s * 37 + a * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] hi_byte(bit we, bit ap, int sp, int sz);
    return {we, ap, 1'b0, 3'(sp), 2'(sz)};
  endfunction

  // Target model and response collector, all acting away from the active edge
  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0;
      wait_n = 0;
    end else if (bus_req) begin
      if (wait_n >= bus_delay) begin
        int nb;
        int s;
        s  = int'(bus_space) % 6;
        nb = (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4;
        if (bus_we) begin
          for (int k = 0; k < nb; k++) mem[s][(int'(bus_addr[7:0]) + k) & 255] = bus_wdata[k*8 +: 8];
        end else begin
          for (int k = 0; k < 4; k++) bus_rdata[k*8 +: 8] = mem[s][(int'(bus_addr[7:0]) + k) & 255];
        end
        bus_ready = 1'b1;
        bus_cnt++;
      end else begin
        wait_n++;
      end
    end
    bp_phase = (bp_phase + 1) % 3;
    out_ready = (bp_mode == 0) ? 1'b1 : (bp_phase == 0);
    if (out_valid && out_ready) begin
      rx_buf[rx_cnt & 255] = out_data;
      rx_cnt++;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 in_ready", int'(in_ready), 1);
    check("R11 out_valid", int'(out_valid), 0);
    check("R11 bus_req", int'(bus_req), 0);
    // address registers start at zero: a no-address 8-bit read of space 4
    send(8'h01); send(hi_byte(0, 0, 4, 0));
    settle();
    check("R11 zero address", int'(rx_buf[0]), int'(init_byte(4, 0)));
  endtask

  task automatic t_read_burst();
    int base = rx_cnt;
    send(8'h82); send(hi_byte(0, 1, 0, 2)); send(8'h10); send(8'h00);
    settle();
    check("R3 read byte count", rx_cnt - base, 8);
    for (int i = 0; i < 8; i++)
      check("R1 R5 read byte order", int'(rx_buf[(base + i) & 255]), int'(init_byte(0, 16 + i)));
  endtask

  task automatic t_write16();
    send(8'h83); send(hi_byte(1, 1, 1, 1)); send(8'h20); send(8'h00);
    for (int i = 0; i < 6; i++) send(8'hD0 + 8'(i));
    settle();
    for (int i = 0; i < 6; i++)
      check("R4 write data", int'(mem[1][32 + i]), 'hD0 + i);
  endtask

  task automatic t_write_noinc();
    int b0 = bus_cnt;
    send(8'h03); send(hi_byte(1, 1, 1, 0)); send(8'h40); send(8'h00);
    send(8'hAA); send(8'hBB); send(8'hCC);
    settle();
    check("R5 repeated address", int'(mem[1][64]), 'hCC);
    check("R5 neighbour untouched", int'(mem[1][65]), int'(init_byte(1, 65)));
    check("R5 bus count", bus_cnt - b0, 3);
  endtask

  task automatic t_no_addr();
    int base = rx_cnt;
    send(8'h01); send(hi_byte(0, 0, 1, 0));
    send(8'h01); send(hi_byte(0, 0, 0, 0));
    settle();
    check("R6 space 1 kept address", int'(rx_buf[base & 255]), 'hCC);
    check("R6 space 0 kept address", int'(rx_buf[(base + 1) & 255]), int'(init_byte(0, 24)));
  endtask

  task automatic t_ro_space();
    int b0 = bus_cnt;
    int base;
    send(8'h82); send(hi_byte(1, 1, 2, 0)); send(8'h1E); send(8'h00);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    settle();
    check("R7 protected low byte", int'(mem[2][30]), int'(init_byte(2, 30)));
    check("R7 protected high byte", int'(mem[2][31]), int'(init_byte(2, 31)));
    check("R7 writable word", int'({mem[2][33], mem[2][32]}), 'h4433);
    check("R7 bus count", bus_cnt - b0, 1);
    base = rx_cnt;
    send(8'h01); send(8'h09);
    settle();
    check("R7 forced 16-bit count", rx_cnt - base, 2);
    check("R7 advance past drop", int'({rx_buf[(base + 1) & 255], rx_buf[base & 255]}),
          int'({init_byte(2, 35), init_byte(2, 34)}));
  endtask

  task automatic t_bad_space();
    int b0 = bus_cnt;
    int base = rx_cnt;
    send(8'h82); send(hi_byte(0, 1, 6, 1)); send(8'h00); send(8'h00);
    send(8'h01); send(hi_byte(1, 1, 7, 0)); send(8'h05); send(8'h00); send(8'h77);
    send(8'h01); send(hi_byte(0, 1, 0, 0)); send(8'h05); send(8'h00);
    settle();
    check("R8 response length", rx_cnt - base, 5);
    for (int i = 0; i < 4; i++) check("R8 zero data", int'(rx_buf[(base + i) & 255]), 0);
    check("R8 data consumed", int'(rx_buf[(base + 4) & 255]), int'(init_byte(0, 5)));
    check("R8 only valid access", bus_cnt - b0, 1);
  endtask

  task automatic t_count_zero();
    int base = rx_cnt;
    send(8'h80); send(hi_byte(0, 1, 3, 1)); send(8'h30); send(8'h00);
    settle();
    check("R2 count zero is one", rx_cnt - base, 2);
    check("R2 data", int'(rx_buf[(base + 1) & 255]), int'(init_byte(3, 49)));
  endtask

  task automatic t_overlap();
    int base = rx_cnt;
    bus_delay = 3;
    bp_mode = 1;
    send(8'h83); send(hi_byte(0, 1, 4, 2)); send(8'h08); send(8'h00);
    send(8'h82); send(hi_byte(0, 1, 5, 0)); send(8'h50); send(8'h00);
    repeat (200) @(negedge clk);
    check("R10 total bytes", rx_cnt - base, 14);
    for (int i = 0; i < 12; i++)
      check("R9 R10 first stream", int'(rx_buf[(base + i) & 255]), int'(init_byte(4, 8 + i)));
    for (int i = 0; i < 2; i++)
      check("R10 second stream", int'(rx_buf[(base + 12 + i) & 255]), int'(init_byte(5, 80 + i)));
    bp_mode = 0;
    bus_delay = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 6; s++)
      for (int a = 0; a < 256; a++) mem[s][a] = init_byte(s, a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_burst();
    t_write16();
    t_write_noinc();
    t_no_addr();
    t_ro_space();
    t_bad_space();
    t_count_zero();
    t_overlap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule